// File: doc/BRIEF.md
# Teletext Serial Attribute Decoder

The block takes the character codes of one display row, one code per strobe, from left to right. It keeps the serial display attributes that the control codes in that row set. For every accepted code it emits one registered cell. The cell holds the code to draw, the cell's column index and the attributes in force for that cell: foreground colour, background colour, alphanumeric or graphics mode, flash, conceal, box, double height and contiguous or separated mosaics.

Control codes change the attribute state and are drawn as blanks. There is one exception. While hold graphics is active in graphics mode, a control cell repeats the most recent mosaic character. Some control codes act in their own cell and others only from the next cell. The row-start pulse returns every attribute to its default and restarts the column count. A glyph generator downstream turns each cell into pixels.

Top module: `ttx_attr_decoder`

## Requirements
- R1: Bit 7 of `code_in` is a parity bit and is ignored. The decoded 7-bit code is `code_in[6:0]`. Its group is bits 6..4 and its row is bits 3..0. A code is a control code when bits 6..5 are both zero (0x00 to 0x1F).
- R2: A control cell outputs `cell_code` = 0x20 (space) unless R10 applies. A non-control cell outputs its own 7-bit code.
- R3: `row_start` returns the attributes to white foreground (7), black background (0), alphanumeric mode, steady, not concealed, box off, normal height, contiguous mosaics and hold off. It also restarts the column count at 0. A code that arrives in the same cycle as `row_start` is cell 0 of the new row and uses these defaults. After reset `cell_valid`=0, `cell_code`=0x20, `cell_fg`=7 and every other output is 0. Colour numbers are 0 black, 1 red, 2 green, 3 yellow, 4 blue, 5 magenta, 6 cyan, 7 white.
- R4: Codes 0x00 to 0x07 select alphanumeric mode, and codes 0x10 to 0x17 select graphics mode. Each code also sets the foreground colour to its low three bits. Both changes take effect from the next cell.
- R5: Flash (0x08) takes effect from the next cell. Steady (0x09) takes effect in its own cell.
- R6: Start box (0x0B) takes effect in its own cell. End box (0x0A) takes effect from the next cell.
- R7: Normal height (0x0C) takes effect in its own cell. Double height (0x0D) takes effect from the next cell.
- R8: Conceal (0x18), contiguous mosaics (0x19) and separated mosaics (0x1A) each take effect in their own cell.
- R9: Black background (0x1C) sets the background to 0. New background (0x1D) sets the background to the foreground colour in force in that cell. Both take effect in their own cell.
- R10: Hold graphics (0x1E) takes effect in its own cell. Release graphics (0x1F) takes effect from the next cell. While hold is on and the cell is in graphics mode, a control cell outputs the last mosaic code. A mosaic code is a non-control code with bit 5 set that was drawn in graphics mode since row start. If there is no such code, the control cell outputs 0x20.
- R11: Codes 0x0E, 0x0F and 0x1B change no attribute and are drawn as 0x20.
- R12: At most COLS codes are accepted per row. Any further code gives no output cell and changes no state until the next `row_start`.
- R13: Each accepted code produces `cell_valid` high in the following cycle. The cell carries `cell_col` equal to the code's position in the row, counted from 0. Cycles without `code_valid` produce no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Start of a new row, resets attributes and column |
| code_valid | input | 1 | `code_in` holds a character code this cycle |
| code_in | input | 8 | Received code, bit 7 is parity |
| cell_valid | output | 1 | A decoded cell is presented |
| cell_col | output | 6 | Column index of the cell (width follows COLS) |
| cell_code | output | 7 | Code to draw: the character, a space or the held mosaic |
| cell_fg | output | 3 | Foreground colour |
| cell_bg | output | 3 | Background colour |
| cell_gfx | output | 1 | Graphics mode (1) or alphanumeric mode (0) |
| cell_flash | output | 1 | Flashing |
| cell_conceal | output | 1 | Concealed |
| cell_box | output | 1 | Inside a box |
| cell_dheight | output | 1 | Double height |
| cell_sep | output | 1 | Separated mosaics |

## Verification
Each attribute code is placed with a printable neighbour on each side. This shows whether it acts in its own cell or only from the next, which is the main distinction between set-at and set-after codes. Hold sequences are run with no prior mosaic, with a letter in graphics mode and across a row start. These separate the held-code store from the plain blanking of control cells. Overlong rows, row starts in mid-row and idle gaps exercise the column limit and the timing. A long stream of mixed codes, with parity bits set, is then compared cell by cell with the behavioural model to reach attribute combinations that the directed rows miss.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

  localparam logic [6:0] SPACE_CODE = 7'h20;

  typedef struct packed {
    logic [2:0] fg;
    logic [2:0] bg;
    logic       gfx;
    logic       flash;
    logic       conceal;
    logic       box;
    logic       dbl;
    logic       sep;
    logic       hold;
  } attr_t;

  localparam attr_t ATTR_ROW_DEFAULT = '{
    fg: 3'd7, bg: 3'd0, gfx: 1'b0, flash: 1'b0, conceal: 1'b0,
    box: 1'b0, dbl: 1'b0, sep: 1'b0, hold: 1'b0
  };

  typedef struct packed {
    logic       ctrl;       // code 0x00..0x1F
    logic       bank;       // 0: group 0, 1: group 1 (control banks)
    logic [3:0] sel;        // row within the group
    logic       mosaic_col; // bit 5 set: mosaic-capable group
    logic [6:0] ch;         // parity-stripped code
  } code_info_t;

endpackage

// File: rtl/ttx_code_split.sv
module ttx_code_split
  import ttx_pkg::*;
(
  input  logic [7:0] raw,
  output code_info_t info
);

  logic unused_parity;
  assign unused_parity = raw[7];

  always_comb begin
    info.ch         = raw[6:0];
    info.ctrl       = (raw[6:5] == 2'b00);
    info.bank       = raw[4];
    info.sel        = raw[3:0];
    info.mosaic_col = raw[5];
  end

endmodule

// File: rtl/ttx_attr_track.sv
module ttx_attr_track
  import ttx_pkg::*;
#(
  parameter int COLS  = 40,
  parameter int COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_start,
  input  logic             code_valid,
  input  code_info_t       info,
  output logic             accept,
  output logic [COL_W-1:0] cell_idx,
  output attr_t            disp_attr,
  output logic [6:0]       disp_code
);

  attr_t            attr_q, base, at, nxt;
  logic [6:0]       held_q, held_base, held_nxt;
  logic [COL_W-1:0] col_q, base_col;

  always_comb begin
    base      = row_start ? ATTR_ROW_DEFAULT : attr_q;
    held_base = row_start ? SPACE_CODE : held_q;
    base_col  = row_start ? '0 : col_q;
    accept    = code_valid && (base_col < COL_W'(COLS));

    // attributes that act in their own cell
    at = base;
    if (info.ctrl) begin
      if (!info.bank) begin
        case (info.sel)
          4'h9:    at.flash = 1'b0;
          4'hB:    at.box   = 1'b1;
          4'hC:    at.dbl   = 1'b0;
          default: ;
        endcase
      end else begin
        case (info.sel)
          4'h8:    at.conceal = 1'b1;
          4'h9:    at.sep     = 1'b0;
          4'hA:    at.sep     = 1'b1;
          4'hC:    at.bg      = 3'd0;
          4'hD:    at.bg      = base.fg;
          4'hE:    at.hold    = 1'b1;
          default: ;
        endcase
      end
    end

    // attributes that act from the next cell
    nxt = at;
    if (info.ctrl) begin
      if (!info.sel[3]) begin
        nxt.fg  = info.sel[2:0];
        nxt.gfx = info.bank;
      end else if (!info.bank) begin
        case (info.sel)
          4'h8:    nxt.flash = 1'b1;
          4'hA:    nxt.box   = 1'b0;
          4'hD:    nxt.dbl   = 1'b1;
          default: ;
        endcase
      end else if (info.sel == 4'hF) begin
        nxt.hold = 1'b0;
      end
    end

    if (!info.ctrl)
      disp_code = info.ch;
    else if (at.hold && at.gfx)
      disp_code = held_base;
    else
      disp_code = SPACE_CODE;

    held_nxt  = (!info.ctrl && at.gfx && info.mosaic_col) ? info.ch : held_base;
    disp_attr = at;
    cell_idx  = base_col;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q <= ATTR_ROW_DEFAULT;
      held_q <= SPACE_CODE;
      col_q  <= '0;
    end else if (accept) begin
      attr_q <= nxt;
      held_q <= held_nxt;
      col_q  <= base_col + COL_W'(1);
    end else if (row_start) begin
      attr_q <= ATTR_ROW_DEFAULT;
      held_q <= SPACE_CODE;
      col_q  <= '0;
    end
  end

  // R12: a full row stays full until a row start
  p_full_stall_r12: assert property (@(posedge clk) disable iff (rst)
    code_valid && !row_start && (col_q == COL_W'(COLS)) |=> (col_q == COL_W'(COLS)));

  // R10: release graphics has cleared hold by the following cell
  p_release_hold_r10: assert property (@(posedge clk) disable iff (rst)
    accept && info.ctrl && info.bank && (info.sel == 4'hF) |=> !attr_q.hold);

endmodule

// File: rtl/ttx_cell_reg.sv
module ttx_cell_reg
  import ttx_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             ctrl_i,
  input  logic [COL_W-1:0] idx_i,
  input  attr_t            attr_i,
  input  logic [6:0]       code_i,
  output logic             cell_valid,
  output logic [COL_W-1:0] cell_col,
  output logic [6:0]       cell_code,
  output attr_t            cell_attr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_valid <= 1'b0;
      cell_col   <= '0;
      cell_code  <= SPACE_CODE;
      cell_attr  <= ATTR_ROW_DEFAULT;
    end else begin
      cell_valid <= accept;
      if (accept) begin
        cell_col  <= idx_i;
        cell_code <= code_i;
        cell_attr <= attr_i;
      end
    end
  end

  // R2: a control cell without active hold in graphics is blank
  p_ctrl_blank_r2: assert property (@(posedge clk) disable iff (rst)
    accept && ctrl_i && !(attr_i.hold && attr_i.gfx) |=> (cell_code == SPACE_CODE));

endmodule

// File: rtl/ttx_attr_decoder.sv
module ttx_attr_decoder
  import ttx_pkg::*;
#(
  parameter  int COLS  = 40,
  localparam int COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_start,
  input  logic             code_valid,
  input  logic [7:0]       code_in,
  output logic             cell_valid,
  output logic [COL_W-1:0] cell_col,
  output logic [6:0]       cell_code,
  output logic [2:0]       cell_fg,
  output logic [2:0]       cell_bg,
  output logic             cell_gfx,
  output logic             cell_flash,
  output logic             cell_conceal,
  output logic             cell_box,
  output logic             cell_dheight,
  output logic             cell_sep
);

  code_info_t       info;
  logic             accept;
  logic [COL_W-1:0] idx;
  attr_t            dattr, oattr;
  logic [6:0]       dcode;

  ttx_code_split u_split (
    .raw  (code_in),
    .info (info)
  );

  ttx_attr_track #(.COLS(COLS), .COL_W(COL_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .row_start  (row_start),
    .code_valid (code_valid),
    .info       (info),
    .accept     (accept),
    .cell_idx   (idx),
    .disp_attr  (dattr),
    .disp_code  (dcode)
  );

  ttx_cell_reg #(.COL_W(COL_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .ctrl_i     (info.ctrl),
    .idx_i      (idx),
    .attr_i     (dattr),
    .code_i     (dcode),
    .cell_valid (cell_valid),
    .cell_col   (cell_col),
    .cell_code  (cell_code),
    .cell_attr  (oattr)
  );

  assign cell_fg      = oattr.fg;
  assign cell_bg      = oattr.bg;
  assign cell_gfx     = oattr.gfx;
  assign cell_flash   = oattr.flash;
  assign cell_conceal = oattr.conceal;
  assign cell_box     = oattr.box;
  assign cell_dheight = oattr.dbl;
  assign cell_sep     = oattr.sep;

  // R3: a printable code arriving with the row start shows default attributes
  p_row_default_r3: assert property (@(posedge clk) disable iff (rst)
    code_valid && row_start && (code_in[6:5] != 2'b00) |=>
      cell_valid && (cell_col == '0) && (cell_fg == 3'd7) && (cell_bg == 3'd0) &&
      !cell_gfx && !cell_flash && !cell_conceal && !cell_box && !cell_dheight && !cell_sep);

  // R13: cells appear only one cycle after a strobe
  p_valid_follows_r13: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> $past(code_valid));

  // R13: back-to-back cells in one row step the column by one
  p_col_step_r13: assert property (@(posedge clk) disable iff (rst)
    code_valid && !row_start && cell_valid |=>
      !cell_valid || (cell_col == $past(cell_col) + COL_W'(1)));

endmodule

// File: tb/tb_ttx_attr_decoder.sv
module tb_ttx_attr_decoder;

  localparam int COLS = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       row_start = 1'b0;
  logic       code_valid = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic       cell_valid;
  logic [5:0] cell_col;
  logic [6:0] cell_code;
  logic [2:0] cell_fg, cell_bg;
  logic       cell_gfx, cell_flash, cell_conceal, cell_box, cell_dheight, cell_sep;

  ttx_attr_decoder #(.COLS(COLS)) dut (
    .clk(clk), .rst(rst), .row_start(row_start), .code_valid(code_valid),
    .code_in(code_in), .cell_valid(cell_valid), .cell_col(cell_col),
    .cell_code(cell_code), .cell_fg(cell_fg), .cell_bg(cell_bg),
    .cell_gfx(cell_gfx), .cell_flash(cell_flash), .cell_conceal(cell_conceal),
    .cell_box(cell_box), .cell_dheight(cell_dheight), .cell_sep(cell_sep)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R3";

  // behavioural model state
  int m_fg, m_bg, m_gfx, m_flash, m_conc, m_box, m_dbl, m_sep, m_hold, m_held, m_col;
  // expected cell
  int e_v, e_col, e_code, e_fg, e_bg, e_gfx, e_flash, e_conc, e_box, e_dbl, e_sep;

  task automatic model_row_reset();
    m_fg = 7; m_bg = 0; m_gfx = 0; m_flash = 0; m_conc = 0; m_box = 0;
    m_dbl = 0; m_sep = 0; m_hold = 0; m_held = 32; m_col = 0;
  endtask

  task automatic model_cell(input int raw);
    int c, grp, r;
    int pend_fg, pend_gfx, pend_flash, pend_box, pend_dbl, pend_rel;
    c = raw % 128;
    grp = c / 16;
    r = c % 16;
    pend_fg = -1; pend_gfx = -1; pend_flash = 0; pend_box = 0; pend_dbl = 0; pend_rel = 0;
    if (m_col >= COLS) begin
      e_v = 0;
      return;
    end
    if (grp == 0) begin
      if (r < 8) begin pend_fg = r; pend_gfx = 0; end
      else if (r == 8) pend_flash = 1;
      else if (r == 9) m_flash = 0;
      else if (r == 10) pend_box = 1;
      else if (r == 11) m_box = 1;
      else if (r == 12) m_dbl = 0;
      else if (r == 13) pend_dbl = 1;
    end else if (grp == 1) begin
      if (r < 8) begin pend_fg = r; pend_gfx = 1; end
      else if (r == 8) m_conc = 1;
      else if (r == 9) m_sep = 0;
      else if (r == 10) m_sep = 1;
      else if (r == 12) m_bg = 0;
      else if (r == 13) m_bg = m_fg;
      else if (r == 14) m_hold = 1;
      else if (r == 15) pend_rel = 1;
    end
    e_v = 1; e_col = m_col;
    if (grp >= 2) e_code = c;
    else if (m_hold == 1 && m_gfx == 1) e_code = m_held;
    else e_code = 32;
    e_fg = m_fg; e_bg = m_bg; e_gfx = m_gfx; e_flash = m_flash; e_conc = m_conc;
    e_box = m_box; e_dbl = m_dbl; e_sep = m_sep;
    if (grp >= 2 && m_gfx == 1 && (c & 32) != 0) m_held = c;
    if (pend_fg >= 0) begin m_fg = pend_fg; m_gfx = pend_gfx; end
    if (pend_flash == 1) m_flash = 1;
    if (pend_box == 1) m_box = 0;
    if (pend_dbl == 1) m_dbl = 1;
    if (pend_rel == 1) m_hold = 0;
    m_col = m_col + 1;
  endtask

  task automatic compare();
    checks++;
    if (cell_valid !== (e_v == 1)) begin
      errors++;
      $display("FAIL %s: cell_valid=%0b expected %0d", tag, cell_valid, e_v);
    end else if (e_v == 1) begin
      if (cell_col != e_col || cell_code != e_code || cell_fg != e_fg || cell_bg != e_bg ||
          cell_gfx != e_gfx || cell_flash != e_flash || cell_conceal != e_conc ||
          cell_box != e_box || cell_dheight != e_dbl || cell_sep != e_sep) begin
        errors++;
        $display("FAIL %s: col=%0d code=%h fg=%0d bg=%0d g=%0b f=%0b c=%0b b=%0b d=%0b s=%0b expected col=%0d code=%h fg=%0d bg=%0d g=%0d f=%0d c=%0d b=%0d d=%0d s=%0d",
                 tag, cell_col, cell_code, cell_fg, cell_bg, cell_gfx, cell_flash,
                 cell_conceal, cell_box, cell_dheight, cell_sep,
                 e_col, e_code, e_fg, e_bg, e_gfx, e_flash, e_conc, e_box, e_dbl, e_sep);
      end
    end
  endtask

  // one cycle with a code; inputs change just after a falling edge
  task automatic send(input int raw, input bit rs = 1'b0);
    row_start = rs; code_valid = 1'b1; code_in = 8'(raw);
    if (rs) model_row_reset();
    model_cell(raw);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input bit rs = 1'b0);
    row_start = rs; code_valid = 1'b0; code_in = 8'h00;
    if (rs) model_row_reset();
    e_v = 0;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_row_reset();
    repeat (3) @(negedge clk);
    // R3: reset values
    checks++;
    if (cell_valid !== 1'b0 || cell_code !== 7'h20 || cell_fg !== 3'd7 || cell_bg !== 3'd0 ||
        cell_col !== 6'd0 || cell_gfx || cell_flash || cell_conceal || cell_box ||
        cell_dheight || cell_sep) begin
      errors++;
      $display("FAIL R3: reset outputs v=%0b code=%h fg=%0d expected v=0 code=20 fg=7",
               cell_valid, cell_code, cell_fg);
    end
    rst = 1'b0;
    idle();

    tag = "R1";  send(8'hC1, 1'b1); send(8'hC2); send(8'h35); send(8'h93); send(8'hFF);
    tag = "R4";  send(8'h01, 1'b1); send(8'h42); send(8'h13); send(8'h7F); send(8'h07); send(8'h41);
    tag = "R5";  send(8'h41, 1'b1); send(8'h08); send(8'h41); send(8'h09); send(8'h41);
    tag = "R6";  send(8'h41, 1'b1); send(8'h0B); send(8'h41); send(8'h0A); send(8'h41);
    tag = "R7";  send(8'h41, 1'b1); send(8'h0D); send(8'h41); send(8'h0C); send(8'h41);
    tag = "R8";  send(8'h11, 1'b1); send(8'h18); send(8'h3F); send(8'h1A); send(8'h7F);
                 send(8'h19); send(8'h7F);
    tag = "R9";  send(8'h02, 1'b1); send(8'h1D); send(8'h41); send(8'h05); send(8'h1D);
                 send(8'h1C); send(8'h41);
    tag = "R10"; send(8'h11, 1'b1); send(8'h1E); send(8'h35); send(8'h4A); send(8'h12);
                 send(8'h08); send(8'h1F); send(8'h0C); send(8'h1E); send(8'h06); send(8'h0C);
    tag = "R10"; send(8'h11, 1'b1); send(8'h6F); send(8'h11, 1'b1); send(8'h1E); send(8'h1E);
    tag = "R2";  send(8'h11, 1'b1); send(8'h6F); send(8'h14); send(8'h1E);
    tag = "R11"; send(8'h01, 1'b1); send(8'h0E); send(8'h0F); send(8'h1B); send(8'h41);
    tag = "R12"; send(8'h41, 1'b1);
    for (int i = 1; i < COLS + 3; i++) send(8'h41 + (i % 20));
    tag = "R3";  send(8'h03, 1'b1); send(8'h1D); send(8'h42, 1'b1); send(8'h0B);
                 idle(1'b1); send(8'h43); send(8'h44);
    tag = "R13"; idle(); send(8'h45); idle(); idle(); send(8'h46); idle();

    tag = "R13";
    for (int k = 0; k < 3000; k++) begin
      int pick;
      pick = $urandom % 64;
      if (pick == 0) idle(1'b1);
      else if (pick < 4) idle();
      else send($urandom % 256, (pick == 5));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule